// File: doc/BRIEF.md
# Selectable-Order Delta-Sigma DAC Modulator

This block turns a held stream of signed 16-bit audio samples into a fast, coarse code stream. An external low-pass filter then turns that stream back into an analog signal. The modulator clock is 50 MHz, far above the audio sample rate. A new sample is captured whenever its valid strobe is high. Between strobes the block keeps running on the last captured value.

A mode input selects one of two loops. In first-order mode a single integrator feeds a sign decision. The result is a 1-bit stream on a pin, and the same decision is also shown as a ±1 code. In second-order mode the integrators form a cascade of two. The input is gained by six quantiser steps per full scale, and a rounding quantiser produces a signed 4-bit code. This pushes quantisation noise toward high frequencies.

In both modes the feedback is taken from the code decided on the previous clock. The integrators saturate, so an overdriven loop pins its code rather than wrapping.

Top module: `dsm_dac`

## Requirements
- R1: A sample is captured into the hold register at a clock edge where `in_valid` is high. The loops use the held value from the following edge onward. When `in_valid` is low, `in_sample` is ignored.
- R2: In first-order mode the first integrator adds the held sample and subtracts a feedback term at each edge. The feedback is +32767 when the previous code is +1, and −32768 otherwise (including code 0). The second integrator stays at zero.
- R3: In first-order mode the new code is +1 (4'b0001) if the updated first integrator is greater than zero, and −1 (4'b1111) otherwise. `dac_pin` is high exactly when the code is +1. A DC input x gives a pin duty of (x+32768)/65535.
- R4: In second-order mode the first integrator adds 6 × the held sample and subtracts the previous code × 32768.
- R5: In second-order mode the second integrator adds the updated first integrator and subtracts the previous code × 32768.
- R6: In second-order mode the new code is floor((B + 16384) / 32768), where B is the updated second integrator. It is clamped to the range −8..7 and given in two's complement on `dac_code`. The mean code tracks 6 × sample / 32768.
- R7: In second-order mode `dac_pin` is held low.
- R8: Synchronous active-high `rst` clears both integrators, the code and the hold register. After reset `dac_code` is 0, `dac_pin` is low, and the mode register takes the value of `mode`.
- R9: At an edge where `mode` differs from the registered mode, the integrators and the code clear to zero and the new mode is registered. The loop runs in the new mode from the next edge.
- R10: Each integrator saturates at the signed limits of `INT_W` bits and never wraps. A saturated loop keeps its code at the sign of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = first-order 1-bit loop, 1 = second-order multi-bit loop |
| in_valid | input | 1 | Capture strobe for `in_sample` |
| in_sample | input | IN_W | Signed PCM sample |
| dac_pin | output | 1 | 1-bit stream in first-order mode, low in second-order mode |
| dac_code | output | Q_BITS | Signed quantiser code |

## Verification
Any fault in an integrator, the feedback term or the hold register shows up at the ports within a few clock cycles. `dac_code` and `dac_pin` are registered results of the integrator state, so an integrator error changes the next code decision. The bench tracks an independent model and compares both outputs on every clock, so a divergence is caught on the first cycle where a code differs. Faults that rarely flip a single decision are caught by long-window averages: the pin duty and the mean code drift away from the values set by the held input. Wrap-around in place of saturation shows as a code of the wrong sign while the loop is overdriven.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic {
        MODE_FIRST  = 1'b0,
        MODE_SECOND = 1'b1
    } dsm_mode_e;

    typedef struct packed {
        dsm_mode_e mode;
        logic      clear;
        logic      second;
    } dsm_ctrl_t;

endpackage

// File: rtl/dsm_sample_hold.sv
module dsm_sample_hold #(
    parameter int IN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic signed [IN_W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (in_valid) begin
            hold_q <= in_sample;
        end
    end
endmodule

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
    parameter int INT_W = 32,
    parameter int OP_W  = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic signed [OP_W-1:0]  add_i,
    input  logic signed [OP_W-1:0]  sub_i,
    output logic signed [INT_W-1:0] acc_q,
    output logic signed [INT_W-1:0] acc_d
);
    localparam int SUM_W = OP_W + 1;
    localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({{(SUM_W-INT_W){acc_q[INT_W-1]}}, acc_q})
            + $signed({add_i[OP_W-1], add_i})
            - $signed({sub_i[OP_W-1], sub_i});
        if (clr) begin
            acc_d = '0;
        end else if (sum > HI) begin
            acc_d = HI[INT_W-1:0];
        end else if (sum < LO) begin
            acc_d = LO[INT_W-1:0];
        end else begin
            acc_d = sum[INT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/dsm_quantiser.sv
module dsm_quantiser
    import dsm_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int IN_W   = 16,
    parameter int Q_BITS = 4
) (
    input  dsm_mode_e                mode,
    input  logic signed [INT_W-1:0]  a_next,
    input  logic signed [INT_W-1:0]  b_next,
    output logic signed [Q_BITS-1:0] code_next
);
    localparam int SH = IN_W - 1;
    localparam logic signed [INT_W:0] HALF = (INT_W+1)'(1) <<< (SH - 1);
    localparam logic signed [INT_W:0] QMAX = (INT_W+1)'((1 << (Q_BITS - 1)) - 1);
    localparam logic signed [INT_W:0] QMIN = ~QMAX;
    localparam logic [Q_BITS-1:0]     PLUS1 = Q_BITS'(1);
    localparam logic [Q_BITS-1:0]     MINUS1 = {Q_BITS{1'b1}};

    logic signed [INT_W:0] biased;
    logic signed [INT_W:0] scaled;

    always_comb begin
        biased = $signed({b_next[INT_W-1], b_next}) + HALF;
        scaled = biased >>> SH;
        if (mode == MODE_FIRST) begin
            code_next = (!a_next[INT_W-1] && (a_next != '0)) ? PLUS1 : MINUS1;
        end else if (scaled > QMAX) begin
            code_next = QMAX[Q_BITS-1:0];
        end else if (scaled < QMIN) begin
            code_next = QMIN[Q_BITS-1:0];
        end else begin
            code_next = scaled[Q_BITS-1:0];
        end
    end
endmodule

// File: rtl/dsm_dac.sv
module dsm_dac
    import dsm_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int INT_W  = 32,
    parameter int Q_BITS = 4,
    parameter int GAIN   = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    output logic                     dac_pin,
    output logic signed [Q_BITS-1:0] dac_code
);
    localparam int OP_W = INT_W + 2;
    localparam int SH   = IN_W - 1;
    localparam logic signed [OP_W-1:0] FS_POS = OP_W'((1 << (IN_W - 1)) - 1);
    localparam logic signed [OP_W-1:0] FS_NEG = ~FS_POS;
    localparam logic signed [OP_W-1:0] GAIN_W = OP_W'(GAIN);

    dsm_mode_e                mode_q;
    dsm_ctrl_t                ctrl;
    logic signed [IN_W-1:0]   hold_q;
    logic signed [Q_BITS-1:0] code_q;
    logic signed [Q_BITS-1:0] code_d;
    logic signed [INT_W-1:0]  int_a_q, int_a_d;
    logic signed [INT_W-1:0]  int_b_q, int_b_d;
    logic signed [OP_W-1:0]   hold_ext, gain_in, code_ext;
    logic signed [OP_W-1:0]   fb_first, fb_second, a_ext;
    logic signed [OP_W-1:0]   a_add, a_sub;
    logic                     code_pos;

    always_comb begin
        ctrl.mode   = mode_q;
        ctrl.clear  = (mode != mode_q);
        ctrl.second = (mode_q == MODE_SECOND);
    end

    dsm_sample_hold #(.IN_W(IN_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .hold_q    (hold_q)
    );

    always_comb begin
        code_pos  = !code_q[Q_BITS-1] && (code_q != '0);
        hold_ext  = {{(OP_W-IN_W){hold_q[IN_W-1]}}, hold_q};
        gain_in   = hold_ext * GAIN_W;
        code_ext  = {{(OP_W-Q_BITS){code_q[Q_BITS-1]}}, code_q};
        fb_second = code_ext <<< SH;
        fb_first  = code_pos ? FS_POS : FS_NEG;
        a_add     = ctrl.second ? gain_in : hold_ext;
        a_sub     = ctrl.second ? fb_second : fb_first;
        a_ext     = {{(OP_W-INT_W){int_a_d[INT_W-1]}}, int_a_d};
    end

    dsm_integrator #(.INT_W(INT_W), .OP_W(OP_W)) u_int_a (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl.clear),
        .add_i (a_add),
        .sub_i (a_sub),
        .acc_q (int_a_q),
        .acc_d (int_a_d)
    );

    dsm_integrator #(.INT_W(INT_W), .OP_W(OP_W)) u_int_b (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl.clear || !ctrl.second),
        .add_i (a_ext),
        .sub_i (fb_second),
        .acc_q (int_b_q),
        .acc_d (int_b_d)
    );

    dsm_quantiser #(.INT_W(INT_W), .IN_W(IN_W), .Q_BITS(Q_BITS)) u_quant (
        .mode      (ctrl.mode),
        .a_next    (int_a_d),
        .b_next    (int_b_d),
        .code_next (code_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= dsm_mode_e'(mode);
            code_q <= '0;
        end else if (ctrl.clear) begin
            mode_q <= dsm_mode_e'(mode);
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign dac_code = code_q;
    assign dac_pin  = !ctrl.second && code_pos;
endmodule

// File: rtl/dsm_dac_checker.sv
module dsm_dac_checker #(
    parameter int IN_W   = 16,
    parameter int INT_W  = 32,
    parameter int Q_BITS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    mode,
    input logic                    in_valid,
    input logic                    mode_q,
    input logic [INT_W-1:0]        int_a,
    input logic [INT_W-1:0]        int_b,
    input logic [Q_BITS-1:0]       code_q,
    input logic [IN_W-1:0]         hold_q,
    input logic                    dac_pin
);
    localparam logic [Q_BITS-1:0] PLUS1  = Q_BITS'(1);
    localparam logic [Q_BITS-1:0] MINUS1 = {Q_BITS{1'b1}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (int_a == '0 && int_b == '0 && code_q == '0 && !dac_pin)); // R8

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hold_q)); // R1

    AST_FIRST_CODE_BINARY: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !mode) |=> (code_q == PLUS1 || code_q == MINUS1)); // R3

    AST_FIRST_B_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !mode) |=> (int_b == '0)); // R2

    AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> (int_a == '0 && int_b == '0 && code_q == '0 && mode_q == $past(mode))); // R9

    AST_SECOND_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q && mode) |=> !dac_pin); // R7
endmodule

bind dsm_dac dsm_dac_checker #(.IN_W(IN_W), .INT_W(INT_W), .Q_BITS(Q_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .in_valid (in_valid),
    .mode_q   (mode_q),
    .int_a    (int_a_q),
    .int_b    (int_b_q),
    .code_q   (code_q),
    .hold_q   (hold_q),
    .dac_pin  (dac_pin)
);

// File: tb/dsm_dac_test.sv
module dsm_dac_test;
    localparam int TB_INT_W = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic              dac_pin;
    logic signed [3:0] dac_code;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string tag = "R8";

    longint m_a, m_b, m_hold, na, nb, nc;
    bit     m_mode;
    bit     exp_pin;

    dsm_dac #(.IN_W(16), .INT_W(TB_INT_W), .Q_BITS(4), .GAIN(6)) uut (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .dac_pin   (dac_pin),
        .dac_code  (dac_code)
    );

    always #10 clk = ~clk;

    function automatic longint sat(longint v);
        longint lim = longint'(1) <<< (TB_INT_W - 1);
        if (v > lim - 1) return lim - 1;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_a = 0; m_b = 0; nc = 0; m_hold = 0; m_mode = mode;
        end else begin
            if (mode != m_mode) begin
                m_mode = mode; m_a = 0; m_b = 0; nc = 0;
            end else if (!m_mode) begin
                na  = sat(m_a + m_hold - ((nc > 0) ? 32767 : -32768));
                nc  = (na > 0) ? 1 : -1;
                m_a = na; m_b = 0;
            end else begin
                na  = sat(m_a + 6 * m_hold - nc * 32768);
                nb  = sat(m_b + na - nc * 32768);
                nc  = (nb + 16384) >>> 15;
                if (nc > 7) nc = 7;
                if (nc < -8) nc = -8;
                m_a = na; m_b = nb;
            end
            if (in_valid) m_hold = longint'(in_sample);
        end
    end

    task automatic chk(string req, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            exp_pin = !m_mode && (nc == 1);
            n_vec++;
            if (longint'(dac_code) != nc || dac_pin != exp_pin) begin
                n_bad++;
                $display("FAIL %s code=%0d/%0d (actual/expected) pin=%0b/%0b",
                         tag, dac_code, nc, dac_pin, exp_pin);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic load(input logic signed [15:0] v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = v;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        int ones;
        int sum;
        repeat (3) @(negedge clk);
        chk("R8 reset code", dac_code, 0);
        chk("R8 reset pin", dac_pin, 0);
        rst = 1'b0;

        // R2 R3: zero sample, known first steps
        tag = "R2/R3 zero input";
        @(negedge clk); chk("R3 step1 code", dac_code, 1); chk("R3 step1 pin", dac_pin, 1);
        @(negedge clk); chk("R2 step2 code", dac_code, 1);
        @(negedge clk); chk("R2 step3 code", dac_code, -1); chk("R3 step3 pin", dac_pin, 0);

        // R1: strobe a half-scale value, then offer a different one without strobe
        tag = "R1/R3 held sample";
        load(16'sd16384);
        in_sample = -16'sd30000;
        repeat (16) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            if (dac_pin) ones++;
        end
        chk("R1 R3 duty ones within 4 of 768", (ones >= 764 && ones <= 772) ? 1 : 0, 1);

        // R9 switch to second order
        tag = "R9/R4/R5/R6";
        @(negedge clk); mode = 1'b1;
        @(negedge clk); chk("R9 clear on switch", dac_code, 0);
        load(16'sd4096);
        repeat (64) @(negedge clk);
        sum = 0; ones = 0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            sum += int'(dac_code);
            if (dac_pin) ones++;
        end
        chk("R6 mean code sum near 768", (sum >= 744 && sum <= 792) ? 1 : 0, 1);
        chk("R7 pin low in second order", ones, 0);

        // R6: triangle sweep
        tag = "R4/R5/R6 sweep";
        for (int k = 0; k < 32; k++) begin
            load(16'(((k % 16) - 8) * 2000));
            repeat (62) @(negedge clk);
        end

        // R10: overdrive both ways
        tag = "R10 saturation";
        load(-16'sd32768);
        repeat (3000) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk("R10 negative pinned", dac_code, -4);
        end
        load(16'sd32767);
        repeat (3000) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (dac_code < 3) ones++;
        end
        chk("R10 positive code stays high", ones, 0);

        // R9 back to first order, full negative input
        tag = "R9/R3 back to first order";
        @(negedge clk); mode = 1'b0;
        @(negedge clk); chk("R9 clear on return", dac_code, 0);
        load(-16'sd32768);
        repeat (16) @(negedge clk);
        ones = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (dac_pin) ones++;
        end
        chk("R3 full negative duty", (ones <= 1) ? 1 : 0, 1);

        // R8: reset in the middle of a run
        tag = "R8 mid reset";
        load(16'sd12000);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 mid reset code", dac_code, 0);
        chk("R8 mid reset pin", dac_pin, 0);
        rst = 1'b0;
        tag = "R1/R2 after reset";
        @(negedge clk); chk("R1 R2 hold cleared first step", dac_code, 1);
        repeat (40) @(negedge clk);
        finish_run();
    end
endmodule